// File: doc/BRIEF.md
# Temperature Correction and Limit Checker

This block sits behind a temperature converter that measures three channels (one on-die sensor and two external diodes). For each conversion it receives a valid strobe, a channel index and a raw signed reading in half-degree steps. It adds that channel's signed calibration offset to the reading, clamps the sum to the span of the active output encoding and emits the corrected code one cycle later.

Two output encodings can be chosen at run time. The first is a plain two's complement code. The second is a biased code in which 64 degrees is added, so that readings up to +191.5 degrees still fit. Each channel also has a high and a low threshold, written in whichever encoding is active. When the corrected reading crosses a threshold, a per-channel sticky flag is set. A pulse on the clear input drops all the flags at once.

Top module: `temp_corr_lim`

## Requirements
- R1: After reset, rd_vld is 0, rd_code is 0 and every bit of hi_flag and lo_flag is 0.
- R2: One cycle after a sample with smp_vld=1 and smp_ch<3, rd_vld=1 and rd_ch=smp_ch. The corrected temperature is smp_raw (signed, 0.5 degree per LSB) plus that channel's 8-bit signed offset. The offset is taken in 0.5 degree steps when ofs_coarse=0 and in 1 degree steps (doubled) when ofs_coarse=1. Channel c uses bits [8c+7:8c] of ofs_flat.
- R3: With fmt_tc=1, rd_code is the corrected value as a 9-bit two's complement number of half degrees. With fmt_tc=0, rd_code is the corrected half-degree value plus 128 as an unsigned 9-bit number, so rd_code[8:1] equals whole degrees plus 64 (for example, 36.0 degrees gives 200).
- R4: The corrected value saturates and never wraps. With fmt_tc=1 it is held between -64.0 and +127.5 degrees (codes 0x180 and 0x0FF). With fmt_tc=0 it is held between -64.0 and +191.5 degrees (codes 0 and 511).
- R5: The limits of channel c are lim_hi_flat[9c+8:9c] and lim_lo_flat[9c+8:9c]. They are decoded in the encoding selected by fmt_tc at the time of the sample, so the same limit code means a different temperature in each mode.
- R6: A sample sets hi_flag[c] of its own channel when the corrected value is strictly above the high limit. It sets lo_flag[c] when the value is at or below the low limit. No other channel's flag changes.
- R7: Once set, a flag stays at 1 through later in-range samples until it is cleared.
- R8: A cycle with flag_clr=1 clears every flag on the next edge. A flag that is set by a sample in that same cycle ends at 1.
- R9: A sample with smp_ch=3 is ignored: rd_vld stays 0 and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Raw sample strobe |
| smp_ch | input | 2 | Channel index of the sample (0..2 valid) |
| smp_raw | input | 10 | Raw signed temperature, 0.5 degree per LSB |
| fmt_tc | input | 1 | 1 = two's complement code, 0 = biased (+64 degree) code |
| ofs_coarse | input | 1 | Offset step: 0 = 0.5 degree, 1 = 1 degree |
| ofs_flat | input | 24 | Three signed 8-bit offsets, channel 0 in the low bits |
| lim_hi_flat | input | 27 | Three 9-bit high limits in the active encoding |
| lim_lo_flat | input | 27 | Three 9-bit low limits in the active encoding |
| flag_clr | input | 1 | Clears all sticky flags |
| rd_vld | output | 1 | Corrected reading valid |
| rd_ch | output | 2 | Channel of the corrected reading |
| rd_code | output | 9 | Corrected reading in the active encoding |
| hi_flag | output | 3 | Sticky above-high flags, one per channel |
| lo_flag | output | 3 | Sticky at-or-below-low flags, one per channel |

## Verification
A wrong offset or a wrong saturation bound shows up in rd_code on the cycle right after the sample, so each table vector exposes it at once. A limit decoded in the wrong encoding, or a flag routed to the wrong channel, appears on hi_flag or lo_flag on that same cycle. A lost sticky state only shows after the next in-range sample or a clear pulse. The bench therefore checks flags after sequences of samples, not only after single ones. A channel-index guard that fails shows as an unexpected rd_vld one cycle after the out-of-range sample.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
  typedef enum logic {FMT_O64 = 1'b0, FMT_TC = 1'b1} fmt_e;
endpackage

// File: rtl/tcl_correct.sv
module tcl_correct #(
  parameter int RAW_W  = 10,
  parameter int OFS_W  = 8,
  parameter int CODE_W = 9,
  parameter int IW     = 12
) (
  input  logic signed [RAW_W-1:0]  raw,
  input  logic signed [OFS_W-1:0]  ofs,
  input  logic                     coarse,
  input  tcl_pkg::fmt_e            fmt,
  output logic signed [IW-1:0]     t_sat,
  output logic [CODE_W-1:0]        code
);
  localparam int BIAS    = 2 ** (CODE_W - 2);
  localparam int TC_MAX  = 2 ** (CODE_W - 1) - 1;
  localparam int O64_MAX = 2 ** CODE_W - 1 - BIAS;
  localparam logic signed [IW-1:0] L_LO   = IW'(-BIAS);
  localparam logic signed [IW-1:0] L_TC   = IW'(TC_MAX);
  localparam logic signed [IW-1:0] L_O64  = IW'(O64_MAX);
  localparam logic signed [IW-1:0] L_BIAS = IW'(BIAS);

  function automatic logic signed [IW-1:0] ofs_half(input logic signed [OFS_W-1:0] o,
                                                    input logic c);
    logic signed [IW-1:0] ext;
    ext = $signed({{(IW-OFS_W){o[OFS_W-1]}}, o});
    return c ? (ext <<< 1) : ext;
  endfunction

  function automatic logic signed [IW-1:0] clamp(input logic signed [IW-1:0] t,
                                                 input tcl_pkg::fmt_e f);
    logic signed [IW-1:0] hi;
    hi = (f == tcl_pkg::FMT_TC) ? L_TC : L_O64;
    if (t < L_LO)      return L_LO;
    else if (t > hi)   return hi;
    else               return t;
  endfunction

  function automatic logic [CODE_W-1:0] encode(input logic signed [IW-1:0] t,
                                               input tcl_pkg::fmt_e f);
    logic signed [IW-1:0] b;
    b = t + L_BIAS;
    return (f == tcl_pkg::FMT_TC) ? t[CODE_W-1:0] : b[CODE_W-1:0];
  endfunction

  logic signed [IW-1:0] raw_ext;
  logic signed [IW-1:0] sum;

  assign raw_ext = $signed({{(IW-RAW_W){raw[RAW_W-1]}}, raw});
  assign sum     = raw_ext + ofs_half(ofs, coarse);
  assign t_sat   = clamp(sum, fmt);
  assign code    = encode(t_sat, fmt);
endmodule

// File: rtl/tcl_lim_cmp.sv
module tcl_lim_cmp #(
  parameter int CODE_W = 9,
  parameter int IW     = 12
) (
  input  logic signed [IW-1:0]  t_val,
  input  logic [CODE_W-1:0]     lim_hi,
  input  logic [CODE_W-1:0]     lim_lo,
  input  tcl_pkg::fmt_e         fmt,
  output logic                  above_hi,
  output logic                  atbelow_lo
);
  localparam logic signed [IW-1:0] L_BIAS = IW'(2 ** (CODE_W - 2));

  function automatic logic signed [IW-1:0] decode(input logic [CODE_W-1:0] c,
                                                  input tcl_pkg::fmt_e f);
    if (f == tcl_pkg::FMT_TC)
      return $signed({{(IW-CODE_W){c[CODE_W-1]}}, c});
    else
      return $signed({{(IW-CODE_W){1'b0}}, c}) - L_BIAS;
  endfunction

  assign above_hi   = t_val >  decode(lim_hi, fmt);
  assign atbelow_lo = t_val <= decode(lim_lo, fmt);
endmodule

// File: rtl/tcl_flag_bank.sv
module tcl_flag_bank #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hi_set,
  input  logic [NCH-1:0] lo_set,
  input  logic           clr,
  output logic [NCH-1:0] hi_flag,
  output logic [NCH-1:0] lo_flag
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_flag[c] <= 1'b0;
        lo_flag[c] <= 1'b0;
      end else begin
        hi_flag[c] <= (hi_flag[c] & ~clr) | hi_set[c];
        lo_flag[c] <= (lo_flag[c] & ~clr) | lo_set[c];
      end
    end

    // R7: a set flag survives any cycle without a clear
    a_r7_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_flag[c] && !clr) |=> hi_flag[c]);
    a_r7_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_flag[c] && !clr) |=> lo_flag[c]);
    // R8: a clear with no concurrent set empties the flag
    a_r8_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hi_set[c]) |=> !hi_flag[c]);
    a_r8_lo_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !lo_set[c]) |=> !lo_flag[c]);
  end

  // R6: one sample touches at most one channel
  a_r6_one_hi: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hi_set));
  a_r6_one_lo: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lo_set));
endmodule

// File: rtl/temp_corr_lim.sv
module temp_corr_lim #(
  parameter int NCH    = 3,
  parameter int RAW_W  = 10,
  parameter int OFS_W  = 8,
  parameter int CODE_W = 9,
  parameter int CHW    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic [CHW-1:0]          smp_ch,
  input  logic [RAW_W-1:0]        smp_raw,
  input  logic                    fmt_tc,
  input  logic                    ofs_coarse,
  input  logic [NCH*OFS_W-1:0]    ofs_flat,
  input  logic [NCH*CODE_W-1:0]   lim_hi_flat,
  input  logic [NCH*CODE_W-1:0]   lim_lo_flat,
  input  logic                    flag_clr,
  output logic                    rd_vld,
  output logic [CHW-1:0]          rd_ch,
  output logic [CODE_W-1:0]       rd_code,
  output logic [NCH-1:0]          hi_flag,
  output logic [NCH-1:0]          lo_flag
);
  import tcl_pkg::*;

  localparam int WMAX = (RAW_W > OFS_W + 1) ? RAW_W : OFS_W + 1;
  localparam int IW   = ((WMAX > CODE_W) ? WMAX : CODE_W) + 2;
  localparam int BIAS = 2 ** (CODE_W - 2);

  fmt_e                 fmt;
  logic                 ch_ok;
  logic                 take;
  logic [CHW-1:0]       sel;
  logic [OFS_W-1:0]     ofs_sel;
  logic [CODE_W-1:0]    hi_sel, lo_sel;
  logic signed [IW-1:0] t_sat;
  logic [CODE_W-1:0]    code_n;
  logic                 above_hi, atbelow_lo;
  logic [NCH-1:0]       ch_dec, hi_set, lo_set;
  fmt_e                 fmt_q;

  assign fmt     = fmt_tc ? FMT_TC : FMT_O64;
  assign ch_ok   = 32'(smp_ch) < NCH;
  assign take    = smp_vld && ch_ok;
  assign sel     = ch_ok ? smp_ch : '0;
  assign ofs_sel = ofs_flat[sel*OFS_W +: OFS_W];
  assign hi_sel  = lim_hi_flat[sel*CODE_W +: CODE_W];
  assign lo_sel  = lim_lo_flat[sel*CODE_W +: CODE_W];

  tcl_correct #(.RAW_W(RAW_W), .OFS_W(OFS_W), .CODE_W(CODE_W), .IW(IW)) u_corr (
    .raw    ($signed(smp_raw)),
    .ofs    ($signed(ofs_sel)),
    .coarse (ofs_coarse),
    .fmt    (fmt),
    .t_sat  (t_sat),
    .code   (code_n)
  );

  tcl_lim_cmp #(.CODE_W(CODE_W), .IW(IW)) u_cmp (
    .t_val      (t_sat),
    .lim_hi     (hi_sel),
    .lim_lo     (lo_sel),
    .fmt        (fmt),
    .above_hi   (above_hi),
    .atbelow_lo (atbelow_lo)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign ch_dec[c] = take && (32'(smp_ch) == c);
  end
  assign hi_set = ch_dec & {NCH{above_hi}};
  assign lo_set = ch_dec & {NCH{atbelow_lo}};

  tcl_flag_bank #(.NCH(NCH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_set  (hi_set),
    .lo_set  (lo_set),
    .clr     (flag_clr),
    .hi_flag (hi_flag),
    .lo_flag (lo_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_ch   <= '0;
      rd_code <= '0;
      fmt_q   <= FMT_O64;
    end else begin
      rd_vld <= take;
      if (take) begin
        rd_ch   <= smp_ch;
        rd_code <= code_n;
        fmt_q   <= fmt;
      end
    end
  end

  // R9: an out-of-range channel never produces a reading
  a_r9_bad_ch: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !ch_ok) |=> !rd_vld);
  // R2: every reading carries a real channel index
  a_r2_ch_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> (32'(rd_ch) < NCH));
  // R4: two's complement readings never fall below -64 degrees
  a_r4_tc_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && fmt_q == FMT_TC && rd_code[CODE_W-1]) |->
      (rd_code >= CODE_W'(2 ** CODE_W - BIAS)));
endmodule

// File: tb/temp_corr_lim_tb.sv
module temp_corr_lim_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [1:0]  smp_ch = '0;
  logic [9:0]  smp_raw = '0;
  logic        fmt_tc = 1'b1;
  logic        ofs_coarse = 1'b0;
  logic [23:0] ofs_flat = '0;
  logic [26:0] lim_hi_flat = '0;
  logic [26:0] lim_lo_flat = '0;
  logic        flag_clr = 1'b0;
  logic        rd_vld;
  logic [1:0]  rd_ch;
  logic [8:0]  rd_code;
  logic [2:0]  hi_flag, lo_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  temp_corr_lim u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_ch(smp_ch), .smp_raw(smp_raw),
    .fmt_tc(fmt_tc), .ofs_coarse(ofs_coarse), .ofs_flat(ofs_flat),
    .lim_hi_flat(lim_hi_flat), .lim_lo_flat(lim_lo_flat), .flag_clr(flag_clr),
    .rd_vld(rd_vld), .rd_ch(rd_ch), .rd_code(rd_code), .hi_flag(hi_flag), .lo_flag(lo_flag)
  );

  // {ch[2], raw[10], fmt_tc, coarse, ofs[8], expected code[9]}
  localparam logic [30:0] VEC [16] = '{
    {2'd0,  10'sd50,  1'b1, 1'b0,  8'sd0,   9'd50 },
    {2'd1,  10'sd50,  1'b1, 1'b0,  8'sd6,   9'd56 },
    {2'd2,  10'sd50,  1'b1, 1'b1,  8'sd6,   9'd62 },
    {2'd0,  10'sd50,  1'b0, 1'b0,  8'sd0,   9'd178},
    {2'd0,  10'sd72,  1'b0, 1'b0,  8'sd0,   9'd200},
    {2'd1,  10'sd0,   1'b0, 1'b1, -8'sd4,   9'd120},
    {2'd2,  10'sd500, 1'b1, 1'b0,  8'sd0,   9'd255},
    {2'd2,  10'sd500, 1'b0, 1'b0,  8'sd0,   9'd511},
    {2'd0, -10'sd300, 1'b1, 1'b0,  8'sd0,   9'd384},
    {2'd0, -10'sd300, 1'b0, 1'b0,  8'sd0,   9'd0  },
    {2'd1,  10'sd250, 1'b1, 1'b1,  8'sd127, 9'd255},
    {2'd1, -10'sd100, 1'b1, 1'b1, -8'sd128, 9'd384},
    {2'd2, -10'sd20,  1'b1, 1'b0,  8'sd0,   9'd492},
    {2'd0,  10'sd380, 1'b0, 1'b1,  8'sd2,   9'd511},
    {2'd0,  10'sd382, 1'b0, 1'b0,  8'sd1,   9'd511},
    {2'd0, -10'sd128, 1'b0, 1'b0,  8'sd0,   9'd0  }
  };

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic sample(input logic [1:0] ch, input logic [9:0] raw);
    @(negedge clk);
    smp_vld = 1'b1;
    smp_ch  = ch;
    smp_raw = raw;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd_vld", int'(rd_vld), 0);
    check("R1 rd_code", int'(rd_code), 0);
    check("R1 flags", int'({hi_flag, lo_flag}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    lim_hi_flat = {3{9'd255}};
    lim_lo_flat = {3{9'd256}};
    for (int i = 0; i < 16; i++) begin
      fmt_tc     = VEC[i][18];
      ofs_coarse = VEC[i][17];
      ofs_flat   = {3{VEC[i][16:9]}};
      sample(VEC[i][30:29], VEC[i][28:19]);
      check($sformatf("R2/R3/R4 vec%0d code", i), int'(rd_code), int'(VEC[i][8:0]));
      check($sformatf("R2 vec%0d vld+ch", i), int'({rd_vld, rd_ch}), int'({1'b1, VEC[i][30:29]}));
    end

    // Flags, two's complement mode, channel 1: high 50.0 deg, low 10.0 deg
    fmt_tc = 1'b1; ofs_coarse = 1'b0; ofs_flat = '0;
    lim_hi_flat = {9'd255, 9'd100, 9'd255};
    lim_lo_flat = {9'd256, 9'd20, 9'd256};
    pulse_clr();
    check("R8 clear after table", int'({hi_flag, lo_flag}), 0);
    sample(2'd1, 10'sd100);
    check("R6 equal to high limit", int'({hi_flag, lo_flag}), 0);
    sample(2'd1, 10'sd101);
    check("R6 above high, own channel only", int'({hi_flag, lo_flag}), 6'b010_000);
    sample(2'd1, 10'sd50);
    check("R7 high flag sticky", int'({hi_flag, lo_flag}), 6'b010_000);
    sample(2'd1, 10'sd20);
    check("R6 at low limit", int'({hi_flag, lo_flag}), 6'b010_010);
    pulse_clr();
    check("R8 clear", int'({hi_flag, lo_flag}), 0);

    // R9: channel 3 ignored, even with a reading far above every limit
    sample(2'd3, 10'sd500);
    check("R9 no rd_vld", int'(rd_vld), 0);
    check("R9 flags unchanged", int'({hi_flag, lo_flag}), 0);

    // R8: set and clear in the same cycle, the set wins
    @(negedge clk);
    smp_vld = 1'b1; smp_ch = 2'd1; smp_raw = 10'sd101; flag_clr = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0; flag_clr = 1'b0;
    check("R8 set wins over clear", int'(hi_flag), 3'b010);
    pulse_clr();

    // R5: channel 2 limit codes 200 / 130 in the biased encoding = 36.0 / 1.0 deg
    lim_hi_flat = {9'd200, 9'd255, 9'd255};
    lim_lo_flat = {9'd130, 9'd256, 9'd256};
    fmt_tc = 1'b0;
    sample(2'd2, 10'sd72);
    check("R5 biased at high limit", int'({hi_flag, lo_flag}), 0);
    sample(2'd2, 10'sd73);
    check("R5 biased above high", int'({hi_flag, lo_flag}), 6'b100_000);
    pulse_clr();
    // Same codes in two's complement = 100.0 / 65.0 deg
    fmt_tc = 1'b1;
    sample(2'd2, 10'sd73);
    check("R5 two's complement decode", int'({hi_flag, lo_flag}), 6'b000_100);
    check("R3 code in two's complement", int'(rd_code), 73);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule